// File: doc/BRIEF.md
# DMA Request Synchronizer Channel

This block sits between one peripheral's DMA request line and the DMA controller. In free mode the request passes straight through. In synchronized mode the request is held back until an edge arrives on an external sync input. That edge opens a window, and the window admits a programmed number of DMA acknowledges. When the last acknowledge of the burst lands, the window closes and the channel blocks again until the next edge. Software uses this to pace a stream of transfers from a timer, for example to leave a fixed gap between bytes sent to a slow serial device.

A sync edge that arrives while a burst is still unfinished is flagged as an overrun. The overrun flag is sticky and can drive an interrupt. An optional one-cycle event pulse marks each completed burst. In free mode the same pulse marks every group of acknowledges of the programmed size. Software is expected to drop the sync-enable bit once its transfer is done. If it does not, the next sync edge will find the window still open or closed with no ack, and a window that never drained raises the overrun.

Top module: `dma_req_sync_chan`

## Requirements
- R1: With `sync_en_i` low, `dma_req_o` equals `per_req_i` in the same cycle. Sync edges never set the overrun flag. `evt_o` pulses in the cycle after every (`req_cnt_i`+1)-th acknowledge, counted from leaving synchronized mode or from reset.
- R2: With `sync_en_i` high, a detected sync edge opens a window from the next cycle. The window admits exactly `req_cnt_i`+1 acknowledges, so a value of 0 admits one. While no window is open, `dma_req_o` is 0.
- R3: `evt_o` is a one-cycle pulse in the cycle after the acknowledge that ends a burst, and only if `evt_gen_en_i` is 1 in that acknowledge cycle. Otherwise `evt_o` stays 0.
- R4: A sync edge while a window is open and not closing in that same cycle sets `ovr_flag_o` from the next cycle. This includes the case where the DMA has served no request at all.
- R5: After the final acknowledge of a burst, `dma_req_o` stays 0 until the next sync edge, even if `per_req_i` stays high.
- R6: `ovr_flag_o` stays set until a cycle with `ovr_clr_i` high clears it from the next cycle. A set condition in the same cycle as a clear wins.
- R7: `ovr_irq_o` is high exactly when `ovr_flag_o` and `ovr_irq_en_i` are both high.
- R8: A sync edge in the same cycle as the final acknowledge of a burst reloads the window for a new burst. It does not raise an overrun.
- R9: An edge is a change of `sync_evt_i` between consecutive clock samples, and the first sample is compared against 0. `sync_pol_i` selects which edges count: 00 rising, 01 falling, 10 both, 11 none.
- R10: After reset, `dma_req_o`, `evt_o`, `ovr_flag_o` and `ovr_irq_o` are 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_req_i | input | 1 | Peripheral DMA request |
| dma_ack_i | input | 1 | DMA acknowledge, one per served request |
| sync_evt_i | input | 1 | External sync level, edge-detected |
| sync_en_i | input | 1 | 1 = gate requests by sync windows |
| sync_pol_i | input | 2 | Edge select: 00 rise, 01 fall, 10 both, 11 none |
| req_cnt_i | input | CNT_W | Requests per window minus one |
| evt_gen_en_i | input | 1 | Enable for the burst-end event pulse |
| ovr_irq_en_i | input | 1 | Overrun interrupt enable |
| ovr_clr_i | input | 1 | Write-one clear of the overrun flag |
| dma_req_o | output | 1 | Request forwarded to the DMA controller |
| evt_o | output | 1 | One-cycle burst-end event |
| ovr_flag_o | output | 1 | Sticky synchronization overrun flag |
| ovr_irq_o | output | 1 | Overrun interrupt |

## Verification
The hardest case to reach is a sync edge landing in the very cycle that the final acknowledge closes a window. Here the reload must win and no overrun may appear. The stimulus walks a burst down one acknowledge at a time and raises the sync input in step with the last acknowledge. It then checks that the request passes again in the next cycle, with the event pulse present and the flag clear. A similar timed step drives an overrun edge in the same cycle as a clear, to show that setting the flag takes priority.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_pol_e;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det
  import dma_sync_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_pol_e pol_i,
  output logic      pulse_o
);
  logic lvl_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;

  always_comb begin
    unique case (pol_i)
      EDGE_RISE: pulse_o = rise;
      EDGE_FALL: pulse_o = fall;
      EDGE_BOTH: pulse_o = rise | fall;
      default:   pulse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/req_gate_ctr.sv
module req_gate_ctr #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_en_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic             ack_i,
  input  logic             sync_pulse_i,
  input  logic             evt_gen_en_i,
  output logic             open_o,
  output logic             ovr_hit_o,
  output logic             evt_o
);
  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             evt_d;
  logic             underrun_now;

  assign underrun_now = sync_en_i & open_q & ack_i & (cnt_q == '0);
  assign ovr_hit_o    = sync_en_i & sync_pulse_i & open_q & ~underrun_now;
  assign base         = open_q ? '0 : cnt_q;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    evt_d  = 1'b0;
    if (sync_en_i) begin
      if (open_q && ack_i) begin
        if (cnt_q == '0) begin
          open_d = 1'b0;
          evt_d  = evt_gen_en_i;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      // reload on edge when idle or when the burst closes this cycle
      if (sync_pulse_i && (!open_q || underrun_now)) begin
        open_d = 1'b1;
        cnt_d  = req_cnt_i;
      end
    end else begin
      // free mode: count acks upward, abandon any open window
      open_d = 1'b0;
      cnt_d  = base;
      if (ack_i) begin
        if (base == req_cnt_i) begin
          cnt_d = '0;
          evt_d = evt_gen_en_i;
        end else begin
          cnt_d = base + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      evt_o  <= 1'b0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      evt_o  <= evt_d;
    end
  end

  assign open_o = open_q;

  assert_blocked_after_underrun_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_now && !sync_pulse_i) |=> !open_q);

  assert_window_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && sync_pulse_i && !open_q) |=> (open_q && cnt_q == $past(req_cnt_i)));

  assert_coincident_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_now && sync_pulse_i) |=> (open_q && cnt_q == $past(req_cnt_i)));

  assert_evt_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_gen_en_i |=> !evt_o);
endmodule

// File: rtl/ovr_status.sv
module ovr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;

  assert_ovr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  assert_ovr_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/dma_req_sync_chan.sv
module dma_req_sync_chan
  import dma_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_req_i,
  input  logic             dma_ack_i,
  input  logic             sync_evt_i,
  input  logic             sync_en_i,
  input  logic [1:0]       sync_pol_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic             evt_gen_en_i,
  input  logic             ovr_irq_en_i,
  input  logic             ovr_clr_i,
  output logic             dma_req_o,
  output logic             evt_o,
  output logic             ovr_flag_o,
  output logic             ovr_irq_o
);
  logic sync_pulse;
  logic win_open;
  logic ovr_hit;

  sync_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (sync_evt_i),
    .pol_i   (edge_pol_e'(sync_pol_i)),
    .pulse_o (sync_pulse)
  );

  req_gate_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_en_i    (sync_en_i),
    .req_cnt_i    (req_cnt_i),
    .ack_i        (dma_ack_i),
    .sync_pulse_i (sync_pulse),
    .evt_gen_en_i (evt_gen_en_i),
    .open_o       (win_open),
    .ovr_hit_o    (ovr_hit),
    .evt_o        (evt_o)
  );

  ovr_status u_ovr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ovr_hit),
    .clr_i    (ovr_clr_i),
    .irq_en_i (ovr_irq_en_i),
    .flag_o   (ovr_flag_o),
    .irq_o    (ovr_irq_o)
  );

  assign dma_req_o = sync_en_i ? (per_req_i & win_open) : per_req_i;

  assert_free_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_en_i && !ovr_flag_o && !ovr_clr_i) |=> !ovr_flag_o);

  assert_closed_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && !win_open) |-> !dma_req_o);
endmodule

// File: tb/dma_req_sync_chan_tb.sv
module dma_req_sync_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic per_req = 1'b0, dma_ack = 1'b0, sync_evt = 1'b0;
  logic sync_en = 1'b1;
  logic [1:0] sync_pol = 2'b00;
  logic [CNT_W-1:0] req_cnt = 5'd2;
  logic evt_gen_en = 1'b1, ovr_irq_en = 1'b1, ovr_clr = 1'b0;
  logic dma_req, evt, ovr_flag, ovr_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_sync_chan #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .per_req_i(per_req), .dma_ack_i(dma_ack),
    .sync_evt_i(sync_evt), .sync_en_i(sync_en), .sync_pol_i(sync_pol),
    .req_cnt_i(req_cnt), .evt_gen_en_i(evt_gen_en), .ovr_irq_en_i(ovr_irq_en),
    .ovr_clr_i(ovr_clr), .dma_req_o(dma_req), .evt_o(evt),
    .ovr_flag_o(ovr_flag), .ovr_irq_o(ovr_irq)
  );

  // expected = {dma_req, evt, ovr_flag, ovr_irq} for this cycle
  task automatic drv(input logic req, input logic ack, input logic sy,
                     input logic [3:0] e, input string tag);
    per_req = req; dma_ack = ack; sync_evt = sy;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      if (exp_q.size() > 0) begin
        logic [3:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {dma_req, evt, ovr_flag, ovr_irq};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: {req,evt,ovr,irq} actual %b expected %b at %0t", t, a, e, $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    drv(1'b0, 1'b0, 1'b0, 4'b0000, "R10 reset state");
    rst_ni = 1'b1;
    // basic burst of 3, rising edge
    drv(1, 0, 0, 4'b0000, "R2 blocked before edge");
    drv(1, 0, 1, 4'b0000, "R2 edge cycle still blocked");
    drv(1, 1, 1, 4'b1000, "R2 ack1");
    drv(1, 1, 0, 4'b1000, "R9 fall ignored, ack2");
    drv(1, 1, 0, 4'b1000, "R2 ack3");
    drv(1, 0, 0, 4'b0100, "R5 blocked after burst, R3 evt");
    drv(1, 0, 0, 4'b0000, "R3 evt one cycle");
    // overrun
    drv(0, 0, 1, 4'b0000, "R2 edge");
    drv(1, 1, 0, 4'b1000, "R2 ack1");
    drv(0, 0, 1, 4'b0000, "R4 edge while open");
    drv(1, 0, 0, 4'b1011, "R4 overrun set, R7 irq");
    drv(0, 0, 0, 4'b0011, "R6 sticky");
    ovr_irq_en = 1'b0;
    drv(0, 0, 0, 4'b0010, "R7 irq masked");
    ovr_irq_en = 1'b1;
    drv(0, 0, 0, 4'b0011, "R7 irq unmasked");
    ovr_clr = 1'b1;
    drv(0, 0, 0, 4'b0011, "R6 clear cycle");
    ovr_clr = 1'b0;
    drv(0, 0, 0, 4'b0000, "R6 cleared");
    drv(1, 1, 0, 4'b1000, "R2 ack2");
    drv(1, 1, 0, 4'b1000, "R2 ack3");
    drv(1, 0, 0, 4'b0100, "R5 closed, R3 evt");
    // set beats clear
    drv(0, 0, 1, 4'b0000, "R2 edge");
    drv(0, 0, 0, 4'b0000, "R2 idle open");
    ovr_clr = 1'b1;
    drv(0, 0, 1, 4'b0000, "R6 edge with clear");
    ovr_clr = 1'b0;
    drv(0, 0, 0, 4'b0011, "R6 set beats clear");
    ovr_clr = 1'b1;
    drv(0, 0, 0, 4'b0011, "R6 clear again");
    ovr_clr = 1'b0;
    drv(0, 0, 0, 4'b0000, "R6 cleared");
    // coincident edge and final ack
    drv(1, 1, 0, 4'b1000, "R8 ack1");
    drv(1, 1, 0, 4'b1000, "R8 ack2");
    drv(1, 1, 1, 4'b1000, "R8 final ack with edge");
    drv(1, 0, 0, 4'b1100, "R8 reloaded, no overrun");
    drv(1, 1, 0, 4'b1000, "R8 ack1 of new burst");
    drv(1, 1, 0, 4'b1000, "R8 ack2");
    drv(1, 1, 0, 4'b1000, "R8 ack3");
    drv(0, 0, 0, 4'b0100, "R3 evt after reloaded burst");
    // single request, event disabled
    req_cnt = 5'd0; evt_gen_en = 1'b0;
    drv(0, 0, 1, 4'b0000, "R2 edge count 0");
    drv(1, 1, 0, 4'b1000, "R2 single ack");
    drv(1, 0, 0, 4'b0000, "R3 evt suppressed, R5 blocked");
    evt_gen_en = 1'b1;
    // polarity: falling
    sync_pol = 2'b01;
    drv(0, 0, 1, 4'b0000, "R9 rise under fall mode");
    drv(1, 0, 1, 4'b0000, "R9 rise ignored");
    drv(0, 0, 0, 4'b0000, "R9 falling edge");
    drv(1, 1, 0, 4'b1000, "R9 fall opened window");
    drv(0, 0, 0, 4'b0100, "R3 evt fall mode");
    // both
    sync_pol = 2'b10;
    drv(0, 0, 1, 4'b0000, "R9 both rise");
    drv(1, 1, 1, 4'b1000, "R9 both window");
    drv(0, 0, 0, 4'b0100, "R9 both fall edge");
    drv(1, 1, 0, 4'b1000, "R9 both fall window");
    drv(0, 0, 0, 4'b0100, "R3 evt both mode");
    // none
    sync_pol = 2'b11;
    drv(0, 0, 1, 4'b0000, "R9 none rise");
    drv(1, 0, 1, 4'b0000, "R9 none blocked");
    drv(0, 0, 0, 4'b0000, "R9 none fall");
    drv(1, 0, 0, 4'b0000, "R9 none still blocked");
    sync_pol = 2'b00;
    // free mode, event every 2 acks
    sync_en = 1'b0; req_cnt = 5'd1;
    drv(1, 0, 0, 4'b1000, "R1 pass through");
    drv(0, 0, 0, 4'b0000, "R1 pass low");
    drv(1, 1, 0, 4'b1000, "R1 ack1");
    drv(1, 1, 1, 4'b1000, "R1 ack2 with edge");
    drv(0, 0, 0, 4'b0100, "R1 free evt");
    drv(1, 0, 0, 4'b1000, "R1 edge caused no overrun");
    // DMA stops serving: stale window overruns
    sync_en = 1'b1;
    drv(0, 0, 1, 4'b0000, "R4 edge opens");
    drv(1, 0, 0, 4'b1000, "R4 no ack");
    drv(1, 0, 0, 4'b1000, "R4 no ack");
    drv(0, 0, 1, 4'b0000, "R4 edge without acks");
    drv(0, 0, 0, 4'b0011, "R4 overrun without acks");
    drv(0, 0, 0, 4'b0011, "R6 held");
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule